// File: doc/BRIEF.md
# Reloading Down-Counter Timer Bank

The block holds three countdown timers behind a plain register bus (address, write enable, write data, combinational read data). Timers 0 and 1 are 16 bits wide and timer 2 is 32 bits wide. Each timer has four registers: a reload value, the live count, a control word and an interrupt-clear strobe.

An enabled timer decrements once per tick. The tick comes from one of two single-cycle tick-enable inputs, and a control bit picks which one. When the count is zero and another tick arrives, the timer underflows. In periodic mode it then reloads from its load register. In free-running mode it wraps to all ones. In both modes it sets a sticky interrupt output. Any write to the timer's clear register drops that interrupt.

The block is meant to drive a periodic system tick from a prescaled clock. It also provides general countdown intervals.

Top module: `cdt_bank`

## Requirements
- R1: Timer windows start at byte addresses 0x00, 0x20 and 0x80 for timers 0, 1 and 2. Inside a window, offset 0x0 is load, 0x4 is value, 0x8 is control and 0xC is clear. Any other address reads 0, and a write to it changes no register.
- R2: The control register has three bits: bit 7 is enable, bit 6 is periodic mode and bit 3 is fast-tick select. All other control bits read as 0. After reset every register, count and interrupt is 0.
- R3: A write to the load register sets both the load value and the count on the following cycle. A tick that arrives in the same cycle as that write is discarded.
- R4: An enabled timer decrements by one on each cycle in which its selected tick input is high. With bit 3 = 1 the selected input is `tick_fast`; with bit 3 = 0 it is `tick_slow`. The other input has no effect on the timer.
- R5: In periodic mode, a tick at count 0 reloads the load value. A load value N therefore gives an underflow every N+1 ticks.
- R6: In free-running mode, a tick at count 0 wraps the count to all ones: 0xFFFF for the 16-bit timers and 0xFFFFFFFF for the 32-bit timer.
- R7: An underflow sets that timer's interrupt one cycle later. The interrupt stays set through later ticks.
- R8: A write of any data to a clear register drops that timer's interrupt one cycle later. If an underflow happens in the same cycle as the clear write, the interrupt stays set.
- R9: While the enable bit is 0, the count holds its value and no new interrupt is raised. An interrupt that is already pending stays set.
- R10: Reading the value register returns the live count, zero-extended to 32 bits. Writes to the value register are ignored.
- R11: The 16-bit timers keep only the low 16 bits of a load write and read them back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| tick_fast | input | 1 | Fast single-cycle tick enable |
| tick_slow | input | 1 | Slow single-cycle tick enable |
| irq | output | 3 | Sticky underflow interrupt, one bit per timer |

## Verification
Read data is combinational, so a register value is due in the same cycle that its address is presented. A write or a tick is due one clock after the edge that samples it, in both the count and the interrupt. The bench drives every stimulus at a falling edge, holds it across exactly one rising edge, and queues each expectation only after that edge has passed. The monitor compares a quarter period after the next falling edge. At that point every register affected by the stimulus has settled and no new edge has arrived. The corner cases each get a single dedicated cycle: a tick together with a load write, and an underflow together with a clear write.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  localparam int unsigned NUM_TMR  = 3;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned EN_BIT   = 7;
  localparam int unsigned PER_BIT  = 6;
  localparam int unsigned FAST_BIT = 3;

  typedef enum logic [1:0] {
    REG_LOAD  = 2'd0,
    REG_VALUE = 2'd1,
    REG_CTRL  = 2'd2,
    REG_CLEAR = 2'd3
  } reg_sel_e;

  // counter width of each timer
  function automatic int unsigned chan_width(input int unsigned idx);
    return (idx == 2) ? 32 : 16;
  endfunction

  // byte base address of each timer window
  function automatic logic [31:0] chan_base(input int unsigned idx);
    case (idx)
      0:       return 32'h00;
      1:       return 32'h20;
      default: return 32'h80;
    endcase
  endfunction

endpackage

// File: rtl/cdt_decode.sv
module cdt_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NUM    = cdt_pkg::NUM_TMR
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM-1:0]    hit,
  output cdt_pkg::reg_sel_e rsel
);

  logic aligned;
  assign aligned = (addr[1:0] == 2'b00);
  assign rsel    = cdt_pkg::reg_sel_e'(addr[3:2]);

  for (genvar g = 0; g < NUM; g++) begin : g_win
    localparam logic [31:0] BASE = cdt_pkg::chan_base(g);
    assign hit[g] = aligned && (addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]);
  end

endmodule

// File: rtl/cdt_channel.sv
module cdt_channel #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_fast,
  input  logic         tick_slow,
  input  logic         wr_load,
  input  logic         wr_ctrl,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  output logic [31:0]  load_rd,
  output logic [31:0]  count_rd,
  output logic [31:0]  ctrl_rd,
  output logic         irq
);
  import cdt_pkg::*;

  logic [W-1:0] load_q, count_q, count_nxt;
  logic         en_q, per_q, fast_q, irq_q;
  logic         tick_sel, step, uflow;

  // next count after one tick
  function automatic logic [W-1:0] next_count(input logic [W-1:0] cnt,
                                              input logic [W-1:0] ld,
                                              input logic         periodic);
    if (cnt == '0) return periodic ? ld : '1;
    return cnt - W'(1);
  endfunction

  assign tick_sel  = fast_q ? tick_fast : tick_slow;
  assign step      = en_q & tick_sel & ~wr_load;
  assign uflow     = step & (count_q == '0);
  assign count_nxt = next_count(count_q, load_q, per_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= '0;
      count_q <= '0;
    end else if (wr_load) begin
      load_q  <= wdata;
      count_q <= wdata;
    end else if (step) begin
      count_q <= count_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      per_q  <= 1'b0;
      fast_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q   <= wdata[EN_BIT];
      per_q  <= wdata[PER_BIT];
      fast_q <= wdata[FAST_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (uflow)  irq_q <= 1'b1;
    else if (wr_clr) irq_q <= 1'b0;
  end

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[EN_BIT]   = en_q;
    ctrl_rd[PER_BIT]  = per_q;
    ctrl_rd[FAST_BIT] = fast_q;
  end

  assign load_rd  = 32'(load_q);
  assign count_rd = 32'(count_q);
  assign irq      = irq_q;

  // R3
  load_takes_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> count_q == $past(wdata));

  // R4
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count_q != '0) |=> count_q == $past(count_q) - W'(1));

  // R5
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && per_q) |=> count_q == $past(load_q));

  // R6
  freerun_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && !per_q) |=> &count_q);

  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |=> irq_q);

  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !uflow) |=> !irq_q);

  // R9
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_load) |=> $stable(count_q));

  // R9
  disabled_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !irq_q) |=> !irq_q);

endmodule

// File: rtl/cdt_bank.sv
module cdt_bank #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_we,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic                        tick_fast,
  input  logic                        tick_slow,
  output logic [cdt_pkg::NUM_TMR-1:0] irq
);
  import cdt_pkg::*;

  localparam int unsigned N = NUM_TMR;

  logic [N-1:0] hit;
  reg_sel_e     rsel;
  logic [31:0]  rd_load  [N];
  logic [31:0]  rd_count [N];
  logic [31:0]  rd_ctrl  [N];

  cdt_decode #(.ADDR_W(ADDR_W), .NUM(N)) u_decode (
    .addr (bus_addr),
    .hit  (hit),
    .rsel (rsel)
  );

  for (genvar g = 0; g < N; g++) begin : g_chan
    localparam int unsigned CW = chan_width(g);
    logic wr_sel;
    assign wr_sel = bus_we & hit[g];

    cdt_channel #(.W(CW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_fast (tick_fast),
      .tick_slow (tick_slow),
      .wr_load   (wr_sel && rsel == REG_LOAD),
      .wr_ctrl   (wr_sel && rsel == REG_CTRL),
      .wr_clr    (wr_sel && rsel == REG_CLEAR),
      .wdata     (bus_wdata[CW-1:0]),
      .load_rd   (rd_load[g]),
      .count_rd  (rd_count[g]),
      .ctrl_rd   (rd_ctrl[g]),
      .irq       (irq[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) begin
        case (rsel)
          REG_LOAD:  bus_rdata = rd_load[i];
          REG_VALUE: bus_rdata = rd_count[i];
          REG_CTRL:  bus_rdata = rd_ctrl[i];
          default:   bus_rdata = '0;
        endcase
      end
    end
  end

  // R1
  single_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

endmodule

// File: tb/cdt_bank_test.sv
module cdt_bank_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_fast = 1'b0;
  logic        tick_slow = 1'b0;
  logic [2:0]  irq;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    bit          is_irq;
    logic [7:0]  addr;
    int          idx;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t scb_q[$];

  cdt_bank uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow),
    .irq       (irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // monitor: compares a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD / 4);
      while (scb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = scb_q.pop_front();
        act = it.is_irq ? 32'(irq[it.idx]) : bus_rdata;
        checks++;
        if (act !== it.exp) begin
          fails++;
          if (it.is_irq)
            $display("FAIL %s: irq[%0d] actual=%h expected=%h", it.req, it.idx, act, it.exp);
          else
            $display("FAIL %s: addr %h actual=%h expected=%h", it.req, it.addr, act, it.exp);
        end
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic write_tick(input logic [7:0] a, input logic [31:0] d, input bit f, input bit s);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; tick_fast = f; tick_slow = s;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0; tick_fast = 1'b0; tick_slow = 1'b0;
  endtask

  task automatic pulse(input bit f, input bit s, input int n);
    for (int k = 0; k < n; k++) begin
      tick_fast = f; tick_slow = s;
      @(posedge clk); @(negedge clk);
      tick_fast = 1'b0; tick_slow = 1'b0;
    end
  endtask

  task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string req);
    item_t it;
    bus_addr = a; bus_we = 1'b0;
    it.is_irq = 1'b0; it.addr = a; it.idx = 0; it.exp = e; it.req = req;
    scb_q.push_back(it);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic exp_irq(input int i, input logic e, input string req);
    item_t it;
    it.is_irq = 1'b1; it.addr = '0; it.idx = i; it.exp = 32'(e); it.req = req;
    scb_q.push_back(it);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not end actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    exp_rd(8'h08, 32'h0, "R2");
    exp_rd(8'h04, 32'h0, "R2");
    for (int i = 0; i < 3; i++) exp_irq(i, 1'b0, "R2");

    // R11 / R3 load of a 16-bit timer
    bus_write(8'h00, 32'h1234_0005);
    exp_rd(8'h00, 32'h0000_0005, "R11");
    exp_rd(8'h04, 32'h0000_0005, "R3");

    // R1 window of the 32-bit timer, unmapped address
    bus_write(8'h80, 32'hDEAD_0003);
    exp_rd(8'h80, 32'hDEAD_0003, "R1");
    exp_rd(8'h84, 32'hDEAD_0003, "R3");
    bus_write(8'h40, 32'hFFFF_FFFF);
    exp_rd(8'h40, 32'h0, "R1");
    exp_rd(8'h20, 32'h0, "R1");

    // R2 control bits
    bus_write(8'h08, 32'hFFFF_FFFF);
    exp_rd(8'h08, 32'h0000_00C8, "R2");
    bus_write(8'h08, 32'h48);

    // R9 disabled
    pulse(1, 0, 3);
    exp_rd(8'h04, 32'h5, "R9");
    exp_irq(0, 1'b0, "R9");

    // R4 tick selection
    bus_write(8'h08, 32'hC8);
    pulse(0, 1, 2);
    exp_rd(8'h04, 32'h5, "R4");
    pulse(1, 0, 2);
    exp_rd(8'h04, 32'h3, "R4");

    // R10 value write ignored
    bus_write(8'h04, 32'h77);
    exp_rd(8'h04, 32'h3, "R10");

    // R5 / R7 underflow and reload
    pulse(1, 0, 3);
    exp_rd(8'h04, 32'h0, "R4");
    exp_irq(0, 1'b0, "R7");
    pulse(1, 0, 1);
    exp_rd(8'h04, 32'h5, "R5");
    exp_irq(0, 1'b1, "R7");
    pulse(1, 0, 1);
    exp_rd(8'h04, 32'h4, "R5");
    exp_irq(0, 1'b1, "R7");

    // R8 clear and clear-versus-underflow
    bus_write(8'h0C, 32'h0);
    exp_irq(0, 1'b0, "R8");
    pulse(1, 0, 4);
    write_tick(8'h0C, 32'hABCD, 1, 0);
    exp_irq(0, 1'b1, "R8");
    exp_rd(8'h04, 32'h5, "R5");
    bus_write(8'h0C, 32'h1);
    exp_irq(0, 1'b0, "R8");

    // R6 free-running 16-bit wrap
    bus_write(8'h20, 32'h1);
    bus_write(8'h28, 32'h80);
    pulse(0, 1, 1);
    exp_irq(1, 1'b0, "R6");
    pulse(0, 1, 1);
    exp_rd(8'h24, 32'h0000_FFFF, "R6");
    exp_irq(1, 1'b1, "R7");
    exp_rd(8'h04, 32'h5, "R4");
    exp_irq(0, 1'b0, "R4");

    // R9 pending interrupt survives disable
    bus_write(8'h28, 32'h0);
    pulse(0, 1, 1);
    exp_rd(8'h24, 32'h0000_FFFF, "R9");
    exp_irq(1, 1'b1, "R9");

    // R6 free-running 32-bit wrap
    bus_write(8'h80, 32'h0);
    bus_write(8'h88, 32'h80);
    pulse(0, 1, 1);
    exp_rd(8'h84, 32'hFFFF_FFFF, "R6");
    exp_irq(2, 1'b1, "R6");

    // R3 load wins over a same-cycle tick
    bus_write(8'h88, 32'hC8);
    bus_write(8'h8C, 32'h0);
    exp_irq(2, 1'b0, "R8");
    write_tick(8'h80, 32'h10, 1, 0);
    exp_rd(8'h84, 32'h10, "R3");
    exp_irq(2, 1'b0, "R3");

    // R5 period of N+1 ticks
    bus_write(8'h80, 32'h2);
    pulse(1, 0, 2);
    exp_irq(2, 1'b0, "R5");
    pulse(1, 0, 1);
    exp_irq(2, 1'b1, "R5");
    exp_rd(8'h84, 32'h2, "R5");

    wait (scb_q.size() == 0);
    @(negedge clk);
    #(CLK_PERIOD / 2);
    finish_run();
  end

endmodule